// File: doc/BRIEF.md
# Multi-Link Power and Frame-Sync Controller

This block serves as the control point for up to four serial audio links. Software reaches it through a small 32-bit register port. For each link, software can ask for power by setting a request bit. The block drives that request out to the link. After a fixed settling time it reports an acknowledge, both on a pin and in a register bit.

The block runs a free frame-sync period counter. Its length is set by software through a commit strobe that clears itself. A new length takes effect only at the counter's next wrap, so no frame is ever cut short.

The block also lines up a bank switch across several links. Software marks each link that takes part, then raises a go bit. At the next wrap of the period counter, every marked link gets a one-cycle sync pulse in the same clock cycle. At that moment the marks and the go bit clear together.

Top module: `link_pwr_sync_ctrl`

## Requirements
- R1: A read of byte offset 0x00 returns NUM_LINKS in bits 2:0 and zero in all other bits.
- R2: At offset 0x04, bits NUM_LINKS-1:0 hold the per-link power requests. They can be written and read, and `link_pwr_en` shows them one cycle after the write.
- R3: Acknowledge bit i reads at offset 0x04 bit 8+i and drives `link_pwr_ack[i]`. It takes the value of request i ACK_DELAY cycles after the request changed, both when rising and when falling. Writes to the acknowledge bits have no effect.
- R4: If a request returns to its old value before ACK_DELAY cycles have passed, the acknowledge does not change.
- R5: The period counter runs from 0 up to the active period value and then wraps, so one wrap occurs every period+1 cycles. After reset the period is RESET_PERIOD (default 0x176F).
- R6: At offset 0x0C, bits 14:0 hold the period and bit 15 is the commit strobe. A write with bit 15 set stores the period at once and reads back bit 15 as 1. The counter uses the new period from the next wrap, and bit 15 then reads 0. A write with bit 15 clear leaves the period unchanged.
- R7: At offset 0x0C, bits 16+i are the arm bits and bit 24 is go. With go set, at the next wrap every armed link sees `link_sync_pulse` high for exactly the following cycle. Links that are not armed see no pulse. In that same wrap the arm bits and go clear.
- R8: A write that sets go while its arm field is zero is ignored. Go then reads 0 and no pulse follows.
- R9: Read data is registered. It appears on `reg_rdata` the cycle after `reg_rd` and holds until the next read. Unmapped offsets read as 0.
- R10: After a synchronous reset, requests, acknowledges, arm bits, go, commit and pulses are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| link_pwr_en | output | NUM_LINKS | Power request to each link |
| link_pwr_ack | output | NUM_LINKS | Power acknowledge from each link |
| link_sync_pulse | output | NUM_LINKS | One-cycle synchronized bank-switch pulse |

## Verification
- **Power timer fault.** A wrong settling timer shows as an acknowledge edge on the pin that arrives one or more cycles early or late.
- **Counter or commit fault.** A corrupted period counter or commit latch moves the wrap. The next sync pulse then lands in the wrong cycle. With a short committed period, this shows within about ten cycles. The commit bit also reads back at the wrong time.
- **Arm or go fault.** A wrong arm or go state shows as a pulse on an unarmed link, a missing pulse, or arm and go bits that do not read back as cleared.
- **How faults are caught.** The reference model is compared on every clock, so any of these faults is caught in the first cycle it reaches a port.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int REG_AW = 8;
  localparam int DATA_W = 32;

  localparam logic [REG_AW-1:0] OFS_CAP  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CTL  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_SYNC = 8'h0C;

  localparam int CAP_W      = 3;
  localparam int ACK_LSB    = 8;
  localparam int PRD_W      = 15;
  localparam int COMMIT_BIT = 15;
  localparam int ARM_LSB    = 16;
  localparam int GO_BIT     = 24;
endpackage

// File: rtl/lps_pwr_lane.sv
module lps_pwr_lane #(
  parameter int ACK_DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ack
);
  localparam int CW = $clog2(ACK_DELAY + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(ACK_DELAY - 1);

  logic [CW-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      dly_q <= '0;
    end else if (req != ack) begin
      if (dly_q == DLY_LAST) begin
        ack   <= req;
        dly_q <= '0;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end else begin
      dly_q <= '0;
    end
  end

  // R3: an acknowledge edge always moves toward the request seen on the prior cycle
  a_r3_ack_toward_req: assert property (@(posedge clk) disable iff (rst)
    (ack != $past(ack)) |-> (ack == $past(req)));

  // R4: the settling timer never passes its last step
  a_r4_timer_bound: assert property (@(posedge clk) disable iff (rst)
    dly_q <= DLY_LAST);
endmodule

// File: rtl/lps_sync_engine.sv
module lps_sync_engine #(
  parameter int NUM_LINKS    = 4,
  parameter int PRD_W        = 15,
  parameter int RESET_PERIOD = 'h176F
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [PRD_W-1:0]     wr_period,
  input  logic                 wr_commit,
  input  logic [NUM_LINKS-1:0] wr_arm,
  input  logic                 wr_go,
  output logic [PRD_W-1:0]     shadow_period,
  output logic                 commit_pend,
  output logic [NUM_LINKS-1:0] arm,
  output logic                 go,
  output logic [NUM_LINKS-1:0] pulse
);
  localparam logic [PRD_W-1:0] RST_PRD = PRD_W'(RESET_PERIOD);

  logic [PRD_W-1:0] cnt_q;
  logic [PRD_W-1:0] active_q;
  logic             term;

  assign term = (cnt_q == active_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      active_q      <= RST_PRD;
      shadow_period <= RST_PRD;
      commit_pend   <= 1'b0;
      arm           <= '0;
      go            <= 1'b0;
      pulse         <= '0;
    end else begin
      pulse <= '0;
      if (term) begin
        cnt_q <= '0;
        if (commit_pend) begin
          active_q    <= shadow_period;
          commit_pend <= 1'b0;
        end
        if (go) begin
          pulse <= arm;
          arm   <= '0;
          go    <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (wr) begin
        arm <= wr_arm;
        go  <= wr_go && (|wr_arm);
        if (wr_commit) begin
          shadow_period <= wr_period;
          commit_pend   <= 1'b1;
        end
      end
    end
  end

  // R5: the counter never runs past the active period
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= active_q);

  // R8: a pending go always has at least one armed link
  a_r8_go_needs_arm: assert property (@(posedge clk) disable iff (rst)
    go |-> (|arm));

  // R7: a pulse only copies the arm set that was pending with go
  a_r7_pulse_from_arm: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |-> ($past(go) && (pulse == $past(arm))));

  // R7: go and arm clear at the wrap that fires them
  a_r7_go_clears: assert property (@(posedge clk) disable iff (rst)
    (go && term && !wr) |=> (!go && (arm == '0)));

  // R6: commit clears at the wrap that loads the period
  a_r6_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (commit_pend && term && !wr) |=> !commit_pend);
endmodule

// File: rtl/link_pwr_sync_ctrl.sv
module link_pwr_sync_ctrl #(
  parameter int NUM_LINKS    = 4,
  parameter int ACK_DELAY    = 6,
  parameter int RESET_PERIOD = 'h176F
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [lps_pkg::REG_AW-1:0]   reg_addr,
  input  logic [lps_pkg::DATA_W-1:0]   reg_wdata,
  output logic [lps_pkg::DATA_W-1:0]   reg_rdata,
  output logic [NUM_LINKS-1:0]         link_pwr_en,
  output logic [NUM_LINKS-1:0]         link_pwr_ack,
  output logic [NUM_LINKS-1:0]         link_sync_pulse
);
  import lps_pkg::*;

  logic [NUM_LINKS-1:0] req_q;
  logic                 ctl_wr;
  logic                 sync_wr;
  logic [PRD_W-1:0]     shadow_period;
  logic                 commit_pend;
  logic [NUM_LINKS-1:0] arm;
  logic                 go;
  logic [DATA_W-1:0]    rd_mux;

  assign ctl_wr  = reg_wr && (reg_addr == OFS_CTL);
  assign sync_wr = reg_wr && (reg_addr == OFS_SYNC);

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else if (ctl_wr) req_q <= reg_wdata[NUM_LINKS-1:0];
  end

  assign link_pwr_en = req_q;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
    lps_pwr_lane #(.ACK_DELAY(ACK_DELAY)) u_lane (
      .clk (clk),
      .rst (rst),
      .req (req_q[i]),
      .ack (link_pwr_ack[i])
    );
  end

  lps_sync_engine #(
    .NUM_LINKS   (NUM_LINKS),
    .PRD_W       (PRD_W),
    .RESET_PERIOD(RESET_PERIOD)
  ) u_sync (
    .clk          (clk),
    .rst          (rst),
    .wr           (sync_wr),
    .wr_period    (reg_wdata[PRD_W-1:0]),
    .wr_commit    (reg_wdata[COMMIT_BIT]),
    .wr_arm       (reg_wdata[ARM_LSB +: NUM_LINKS]),
    .wr_go        (reg_wdata[GO_BIT]),
    .shadow_period(shadow_period),
    .commit_pend  (commit_pend),
    .arm          (arm),
    .go           (go),
    .pulse        (link_sync_pulse)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CAP: rd_mux[CAP_W-1:0] = CAP_W'(NUM_LINKS);
      OFS_CTL: begin
        rd_mux[NUM_LINKS-1:0]         = req_q;
        rd_mux[ACK_LSB +: NUM_LINKS]  = link_pwr_ack;
      end
      OFS_SYNC: begin
        rd_mux[PRD_W-1:0]             = shadow_period;
        rd_mux[COMMIT_BIT]            = commit_pend;
        rd_mux[ARM_LSB +: NUM_LINKS]  = arm;
        rd_mux[GO_BIT]                = go;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R2: the power request pins take the written request field
  a_r2_en_follows_write: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (link_pwr_en == $past(reg_wdata[NUM_LINKS-1:0])));

  // R9: read data holds while no read is issued
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/link_pwr_sync_ctrl_bench.sv
`timescale 1ns/1ps
module link_pwr_sync_ctrl_bench;
  localparam int NL  = 4;
  localparam int DLY = 6;
  localparam int RP  = 'h176F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] link_pwr_en, link_pwr_ack, link_sync_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int pulse_seen [NL];

  always #2 clk = ~clk;

  link_pwr_sync_ctrl #(.NUM_LINKS(NL), .ACK_DELAY(DLY), .RESET_PERIOD(RP)) u_link_pwr_sync_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_pwr_en(link_pwr_en),
    .link_pwr_ack(link_pwr_ack), .link_sync_pulse(link_sync_pulse)
  );

  // behavioural reference model
  logic [NL-1:0] m_req, m_ack, m_arm, m_pulse;
  int m_dly [NL];
  int m_cnt, m_act, m_shd;
  bit m_commit, m_go;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v = 0;
    if (a == 8'h00) v = NL;
    else if (a == 8'h04) v = {16'd0, 4'd0, m_ack, 4'd0, m_req};
    else if (a == 8'h0C) v = {7'd0, m_go, 4'd0, m_arm, m_commit, 15'(m_shd)};
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req = 0; m_ack = 0; m_arm = 0; m_pulse = 0; m_go = 0; m_commit = 0;
      m_cnt = 0; m_act = RP; m_shd = RP; m_rdata = 0;
      for (int i = 0; i < NL; i++) m_dly[i] = 0;
    end else begin
      logic [NL-1:0] n_ack, n_arm, n_pulse;
      int n_cnt, n_act, n_shd;
      bit n_go, n_commit;
      if (reg_rd) m_rdata = model_read(reg_addr);
      n_ack = m_ack; n_arm = m_arm; n_pulse = 0; n_go = m_go; n_commit = m_commit;
      n_act = m_act; n_shd = m_shd;
      if (m_cnt == m_act) begin
        n_cnt = 0;
        if (m_commit) begin n_act = m_shd; n_commit = 0; end
        if (m_go) begin n_pulse = m_arm; n_arm = 0; n_go = 0; end
      end else n_cnt = m_cnt + 1;
      for (int i = 0; i < NL; i++) begin
        if (m_req[i] != m_ack[i]) begin
          if (m_dly[i] == DLY - 1) begin n_ack[i] = m_req[i]; m_dly[i] = 0; end
          else m_dly[i] = m_dly[i] + 1;
        end else m_dly[i] = 0;
      end
      if (reg_wr && reg_addr == 8'h04) m_req = reg_wdata[NL-1:0];
      if (reg_wr && reg_addr == 8'h0C) begin
        n_arm = reg_wdata[16 +: NL];
        n_go = reg_wdata[24] && (reg_wdata[16 +: NL] != 0);
        if (reg_wdata[15]) begin n_shd = reg_wdata[14:0]; n_commit = 1; end
      end
      m_ack = n_ack; m_arm = n_arm; m_pulse = n_pulse; m_go = n_go; m_commit = n_commit;
      m_cnt = n_cnt; m_act = n_act; m_shd = n_shd;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 link_pwr_en", 32'(link_pwr_en), 32'(m_req));
      chk("R3 link_pwr_ack", 32'(link_pwr_ack), 32'(m_ack));
      chk("R7 link_sync_pulse", 32'(link_sync_pulse), 32'(m_pulse));
      chk("R9 reg_rdata", reg_rdata, m_rdata);
    end
    for (int i = 0; i < NL; i++)
      if (rst) pulse_seen[i] = 0;
      else if (link_sync_pulse[i]) pulse_seen[i]++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_sync_idle();
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      rd(8'h0C, d);
      if (!d[15] && !d[24]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state, R1 capability
    rd_chk("R10 ctl after reset", 8'h04, 32'h0);
    rd_chk("R10 sync after reset", 8'h0C, 32'h0000_176F);
    rd_chk("R1 capability", 8'h00, 32'd4);
    // R2 / R3 power handshake
    wr(8'h04, 32'h5);
    rd_chk("R3 ack not yet", 8'h04, 32'h0005);
    idle(DLY + 2);
    rd_chk("R3 ack risen", 8'h04, 32'h0505);
    wr(8'h04, 32'h0F05);
    rd_chk("R3 ack bits ignore writes", 8'h04, 32'h0505);
    // R4 aborted request
    wr(8'h04, 32'h7);
    wr(8'h04, 32'h5);
    idle(DLY + 3);
    rd_chk("R4 ack unchanged", 8'h04, 32'h0505);
    wr(8'h04, 32'h0);
    idle(DLY + 2);
    rd_chk("R3 ack fallen", 8'h04, 32'h0000);
    // R6 commit a short period
    wr(8'h0C, 32'h0000_0123);
    rd_chk("R6 period unchanged without commit", 8'h0C, 32'h0000_176F);
    wr(8'h0C, 32'h0000_8009);
    rd_chk("R6 commit pending", 8'h0C, 32'h0000_8009);
    wait_sync_idle();
    rd_chk("R6 commit cleared", 8'h0C, 32'h0000_0009);
    // R7 / R5 arm links 0 and 1, then go
    wr(8'h0C, 32'h0103_0009);
    begin
      int waited = 0;
      while (link_sync_pulse == 0 && waited < 40) begin @(negedge clk); waited++; end
      total++;
      if (waited > 11) begin
        bad++;
        $display("FAIL R5 wrap wait actual=%0d expected<=11", waited);
      end
    end
    wait_sync_idle();
    rd_chk("R7 arm and go cleared", 8'h0C, 32'h0000_0009);
    chk("R7 link0 pulsed once", pulse_seen[0], 1);
    chk("R7 link1 pulsed once", pulse_seen[1], 1);
    chk("R7 link2 not pulsed", pulse_seen[2], 0);
    // R8 go without arm
    wr(8'h0C, 32'h0100_0009);
    rd_chk("R8 go reads 0", 8'h0C, 32'h0000_0009);
    idle(30);
    chk("R8 no pulse link0", pulse_seen[0], 1);
    chk("R8 no pulse link3", pulse_seen[3], 0);
    // R9 unmapped offsets
    rd_chk("R9 unmapped 0x08", 8'h08, 32'h0);
    rd_chk("R9 unmapped 0x10", 8'h10, 32'h0);
    // R5 period zero: wrap every cycle
    wr(8'h0C, 32'h0000_8000);
    wait_sync_idle();
    wr(8'h0C, 32'h0108_0000);
    idle(4);
    chk("R5 period0 pulse link3", pulse_seen[3], 1);
    rd_chk("R7 cleared at period0", 8'h0C, 32'h0);
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule